// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block puts a bank of 8-bit PHY delay registers behind a single 32-bit control/status word. Software loads a register address and a data byte into that word. It then sets a write or read request bit and polls for an acknowledge bit. The block takes a copy of the request operands, waits a fixed number of cycles, and then does the access. On a write it updates the addressed bank entry. On a read it copies the entry into the read-data field of the word. It then raises the acknowledge bit. The acknowledge bit stays high until software clears every request bit, so the handshake has four phases.

The bank holds up to 64 entries. Only the addresses set in a mask parameter hold storage. By default these are 0x00–0x08 for per-speed input delays, and 0x0B, 0x0C and 0x0D for the clock, high-speed and strobe DLL delays. The whole bank is driven out as a flat vector to the delay-line logic.

Top module: `phy_reg_port`

## Requirements
- R1: The access word is laid out as follows. Bits 5:0 are the address, bits 15:8 the write data, bits 23:16 the read data, bit 24 the write request, bit 25 the read request and bit 26 the acknowledge. A CSR write loads the address, the write data and both request bits, and a CSR read returns them unchanged.
- R2: Bits 31:27 and 7:6 always read as zero. A CSR write leaves the read-data field (bits 23:16) and the acknowledge bit (bit 26) unchanged.
- R3: A CSR write that sets the write request makes the acknowledge bit read 1 exactly ACK_DELAY+1 clock edges later. By that edge the addressed bank entry on `phy_regs` (bits a*8+7:a*8) holds the write data.
- R4: The acknowledge bit stays at 1 while either request bit is set. It returns to 0 one edge after the CSR write that clears both request bits.
- R5: A read request gets the acknowledge bit with the same latency as a write request. When the acknowledge bit rises, bits 23:16 already hold the addressed entry, and they keep that value until the next read completes.
- R6: A write to an address outside IMPL_MASK leaves every output unchanged. A read of such an address returns 0.
- R7: The address and data are captured on the edge after the request is seen. A CSR write that changes them while the access is pending does not affect that access.
- R8: If both request bits are set together, the write is done and the read data returns the byte just written.
- R9: Reset clears every bank entry, both request bits, the read-data field and the acknowledge bit.
- R10: Bank contents change only when a write access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the access word |
| csr_wdata | input | 32 | Value written to the access word |
| csr_rdata | output | 32 | Current value of the access word |
| phy_regs | output | NUM_REGS*8 | Bank contents, entry a in bits a*8+7:a*8 |

## Verification
The hardest case to reach from the ports is a change to the address and data while an access is still pending, after the request has been taken but before the acknowledge bit rises. The stimulus gets there by issuing a second CSR write on the very next cycle. That write keeps the request bit set and changes both operand fields, so it falls inside the ACK_DELAY window. Every one of the 64 addresses is also written and then read back. This covers both the storage entries and the unimplemented entries, and the acknowledge latency is counted on each access.

// File: rtl/phy_reg_port.sv
module phy_reg_port #(
  parameter int          NUM_REGS  = 64,
  parameter int          ACK_DELAY = 3,
  parameter logic [63:0] IMPL_MASK = 64'h0000_0000_0000_39FF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_we,
  input  logic [31:0]           csr_wdata,
  output logic [31:0]           csr_rdata,
  output logic [NUM_REGS*8-1:0] phy_regs
);
  localparam int CW = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  logic [5:0]    addr_q, op_addr;
  logic [7:0]    wdat_q, rdat_q, op_data, rd_val;
  logic          wr_q, rd_q, ack_q, op_wr, op_rd;
  logic [CW-1:0] cnt_q;
  st_t           st_q;
  logic [7:0]    bank [NUM_REGS];
  logic          commit, req_any;
  logic          unused_wbits;

  assign req_any      = wr_q | rd_q;
  assign commit       = (st_q == S_BUSY) && (cnt_q == '0);
  assign unused_wbits = ^{csr_wdata[31:26], csr_wdata[23:16], csr_wdata[7:6]};
  assign csr_rdata    = {5'b0, ack_q, rd_q, wr_q, rdat_q, wdat_q, 2'b0, addr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else if (csr_we) begin
      addr_q <= csr_wdata[5:0];
      wdat_q <= csr_wdata[15:8];
      wr_q   <= csr_wdata[24];
      rd_q   <= csr_wdata[25];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (op_addr == 6'(i)) rd_val = bank[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      rdat_q  <= '0;
      op_addr <= '0;
      op_data <= '0;
      op_wr   <= 1'b0;
      op_rd   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_any) begin
          op_addr <= addr_q;
          op_data <= wdat_q;
          op_wr   <= wr_q;
          op_rd   <= rd_q;
          cnt_q   <= CW'(ACK_DELAY - 1);
          st_q    <= S_BUSY;
        end
        S_BUSY: if (cnt_q != '0) begin
          cnt_q <= cnt_q - CW'(1);
        end else begin
          ack_q <= 1'b1;
          st_q  <= S_DONE;
          if (op_rd) rdat_q <= (op_wr && IMPL_MASK[op_addr]) ? op_data : rd_val;
        end
        default: if (!req_any) begin
          ack_q <= 1'b0;
          st_q  <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (!IMPL_MASK[i]) bank[i] <= '0;
        else if (commit && op_wr && op_addr == 6'(i)) bank[i] <= op_data;
    end
  end

  always_comb
    for (int i = 0; i < NUM_REGS; i++) phy_regs[i*8 +: 8] = bank[i];

  // R3
  ack_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(st_q == S_BUSY));

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req_any) |=> ack_q);

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> $past(!req_any));

  // R10
  bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && op_wr) |=> $stable(phy_regs));

  // R5
  rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && op_rd) |=> $stable(rdat_q));
endmodule

// File: tb/tb_phy_reg_port.sv
module tb_phy_reg_port;
  localparam int          N    = 64;
  localparam int          D    = 3;
  localparam logic [63:0] MASK = 64'h0000_0000_0000_39FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_we = 1'b0;
  logic [31:0]   csr_wdata = '0;
  logic [31:0]   csr_rdata;
  logic [N*8-1:0] phy_regs;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic [7:0] exp_bank [N];
  logic [N*8-1:0] snap;

  phy_reg_port #(.NUM_REGS(N), .ACK_DELAY(D), .IMPL_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .phy_regs(phy_regs));

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255) | 8'h01;
  endfunction

  function automatic logic [31:0] word(int a, logic [7:0] d, bit wr, bit rd);
    return {6'b0, rd, wr, 8'h00, d, 2'b00, 6'(a)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(logic [31:0] v);
    @(negedge clk);
    csr_we = 1'b1;
    csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    while (n < 50) begin
      @(negedge clk);
      n++;
      if (csr_rdata[26]) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    for (int a = 0; a < N; a++) exp_bank[a] = '0;
    repeat (3) @(negedge clk);
    check("R9 reset csr", csr_rdata, 32'h0);
    check("R9 reset bank", 32'(phy_regs == '0), 32'h1);
    rst_n = 1'b1;

    for (int a = 0; a < N; a++) begin
      csr_write(word(a, pat(a), 1'b0, 1'b0));
      check("R1 field readback", csr_rdata, {16'h0, pat(a), 2'b00, 6'(a)});
      csr_write(word(a, pat(a), 1'b1, 1'b0));
      check("R1 wr bit readback", 32'(csr_rdata[24]), 32'h1);
      wait_ack(n);
      check("R3 ack latency", 32'(n), 32'(D + 1));
      if (MASK[a]) exp_bank[a] = pat(a);
      check(MASK[a] ? "R3 bank write" : "R6 dropped write",
            32'(phy_regs[a*8 +: 8]), 32'(exp_bank[a]));
      if (a % 16 == 0) begin
        repeat (5) @(negedge clk);
        check("R4 ack held", 32'(csr_rdata[26]), 32'h1);
      end
      csr_write(word(a, pat(a), 1'b0, 1'b0));
      check("R4 ack until clear edge", 32'(csr_rdata[26]), 32'h1);
      @(negedge clk);
      check("R4 ack released", 32'(csr_rdata[26]), 32'h0);
    end

    snap = phy_regs;
    for (int a = 0; a < N; a++) begin
      csr_write(word(a, 8'h00, 1'b0, 1'b1));
      wait_ack(n);
      check("R5 read latency", 32'(n), 32'(D + 1));
      check(MASK[a] ? "R5 read data" : "R6 unimpl read zero",
            32'(csr_rdata[23:16]), 32'(exp_bank[a]));
      csr_write(word(a, 8'h00, 1'b0, 1'b0));
      @(negedge clk);
      check("R5 read data kept", 32'(csr_rdata[23:16]), 32'(exp_bank[a]));
    end
    check("R10 bank unchanged by reads", 32'(phy_regs == snap), 32'h1);

    csr_write(word(2, 8'h00, 1'b0, 1'b1));
    wait_ack(n);
    csr_write(word(2, 8'h00, 1'b0, 1'b0));
    @(negedge clk);
    csr_write(32'hFCFF_00C5);
    check("R2 reserved and ro bits", csr_rdata, {8'h00, exp_bank[2], 8'h00, 8'h05});

    csr_write(word(3, 8'hA5, 1'b1, 1'b0));
    csr_write(word(4, 8'h3C, 1'b1, 1'b0));
    wait_ack(n);
    exp_bank[3] = 8'hA5;
    check("R7 captured addr written", 32'(phy_regs[3*8 +: 8]), 32'hA5);
    check("R7 late addr untouched", 32'(phy_regs[4*8 +: 8]), 32'(exp_bank[4]));
    csr_write(word(4, 8'h3C, 1'b0, 1'b0));
    @(negedge clk);

    csr_write(word(11, 8'h5A, 1'b1, 1'b1));
    wait_ack(n);
    check("R8 combined latency", 32'(n), 32'(D + 1));
    check("R8 combined bank", 32'(phy_regs[11*8 +: 8]), 32'h5A);
    check("R8 combined read", 32'(csr_rdata[23:16]), 32'h5A);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid-run reset csr", csr_rdata, 32'h0);
    check("R9 mid-run reset bank", 32'(phy_regs == '0), 32'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule